// File: doc/BRIEF.md
# GPIO Interrupt Line Router

This block sits between three GPIO controllers and a platform interrupt controller that has fewer inputs than there are GPIO interrupt sources. The three controllers supply 14, 24 and 32 level interrupt lines, 70 sources in all. The interrupt controller side receives 41 lines: 38 dedicated lines and 3 shared lines. There is one shared line for each GPIO controller.

Each bit of a 32-bit steering word picks which of two fixed candidate lines owns one dedicated output. Bits 0..13 pair controller 0 line i with controller 2 line i. Bits 14..31 pair controller 1 line i-14 with controller 2 line i. The candidate that loses is not dropped. It is ORed into the shared output of its own controller. Controller 1 lines 18..23 have no competitor and always own dedicated outputs 32..37.

Routing depends only on the steering word. Software writes the word and reads it back through a plain write-enable port. The interrupt path is purely combinational, so an asserted line reaches the outputs in the same cycle. The block has no streaming traffic, so every pin is a plain level signal with no valid/ready handshake and no back-pressure.

Top module: `irq_line_router`

## Requirements
- R1: After reset the steering word reads back as all zeros.
- R2: When `cfg_wr_en` is high at a rising clock edge, `cfg_wr_data` is stored at that edge. `cfg_rd_data` shows the stored word after the edge and keeps it until the next write. The new routing applies from the same edge.
- R3: For steering bit i in 0..13 equal to 0, `gpio0_irq[i]` drives `irq_out[i]`, and `gpio2_irq[i]` is ORed into the controller 2 shared line `irq_out[40]`.
- R4: For steering bit i in 0..13 equal to 1, `gpio2_irq[i]` drives `irq_out[i]`, and `gpio0_irq[i]` is ORed into the controller 0 shared line `irq_out[38]`.
- R5: For steering bit i in 14..31 equal to 0, `gpio1_irq[i-14]` drives `irq_out[i]`, and `gpio2_irq[i]` is ORed into `irq_out[40]`.
- R6: For steering bit i in 14..31 equal to 1, `gpio2_irq[i]` drives `irq_out[i]`, and `gpio1_irq[i-14]` is ORed into the controller 1 shared line `irq_out[39]`.
- R7: `gpio1_irq[18+k]` drives `irq_out[32+k]` for k in 0..5 for every steering word, and these lines never reach `irq_out[39]`.
- R8: Each shared output is the OR of exactly those lines of its own controller that do not own a dedicated output. A line that owns a dedicated output has no effect on any shared output. A shared output is low when every line of its controller is low.
- R9: The interrupt path is combinational. An input change appears on `irq_out` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the steering register |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the steering word |
| cfg_wr_data | input | 32 | Steering word to store |
| cfg_rd_data | output | 32 | Currently stored steering word |
| gpio0_irq | input | 14 | Interrupt lines from controller 0 |
| gpio1_irq | input | 24 | Interrupt lines from controller 1 |
| gpio2_irq | input | 32 | Interrupt lines from controller 2 |
| irq_out | output | 41 | Dedicated lines 0..37, then the shared lines of controllers 0, 1 and 2 at 38, 39 and 40 |

## Verification
The bench walks a single asserted line across every pair, under both values of the steering bit. A design that mixed up the two pair groups, or that spilled a losing line into the wrong controller's shared output, would light the wrong index. The seam at bit 13/14 and the unpaired controller 1 lines 18..23 get their own scenarios. An off-by-one in the controller 1 offset would move a direct line by one position, and a fixed line leaking into shared line 39 would show up there. Random mixed steering words and inputs are compared with an independent model. A probe made without a clock edge catches any registered stage that delays an interrupt.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Ownership of a dedicated output, as encoded by one steering bit.
  typedef enum logic {
    OWNER_PARTNER = 1'b0,  // controller 0 or 1 line owns the output
    OWNER_WIDE    = 1'b1   // controller 2 line owns the output
  } route_owner_e;

  // OR of the lines selected by a mask.
  function automatic logic masked_any(input logic [63:0] lines,
                                      input logic [63:0] mask);
    return |(lines & mask);
  endfunction

endpackage

// File: rtl/irq_route_cfg_reg.sv
module irq_route_cfg_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      q <= wr_data;
    end
  end

endmodule

// File: rtl/irq_route_pair.sv
module irq_route_pair #(
  parameter int unsigned PAIRS = 14
) (
  input  logic [PAIRS-1:0] sel,
  input  logic [PAIRS-1:0] partner_lines,
  input  logic [PAIRS-1:0] wide_lines,
  output logic [PAIRS-1:0] direct,
  output logic [PAIRS-1:0] partner_spill,
  output logic [PAIRS-1:0] wide_spill
);
  import irq_route_pkg::*;

  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    route_owner_e owner;
    assign owner = route_owner_e'(sel[i]);

    always_comb begin
      direct[i]        = 1'b0;
      partner_spill[i] = 1'b0;
      wide_spill[i]    = 1'b0;
      unique case (owner)
        OWNER_PARTNER: begin
          direct[i]     = partner_lines[i];
          wide_spill[i] = wide_lines[i];
        end
        OWNER_WIDE: begin
          direct[i]        = wide_lines[i];
          partner_spill[i] = partner_lines[i];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge #(
  parameter int unsigned WIDTH = 14
) (
  input  logic [WIDTH-1:0] lines,
  output logic             any
);
  import irq_route_pkg::*;

  localparam int unsigned PAD = 64 - WIDTH;

  logic [63:0] wide;
  if (PAD > 0) begin : g_pad
    assign wide = {{PAD{1'b0}}, lines};
  end else begin : g_nopad
    assign wide = lines[63:0];
  end

  assign any = masked_any(wide, {64{1'b1}});

endmodule

// File: rtl/irq_line_router.sv
module irq_line_router #(
  parameter int unsigned G0_W = 14,
  parameter int unsigned G1_W = 24,
  parameter int unsigned G2_W = 32,
  localparam int unsigned PAIRS_HI = G2_W - G0_W,
  localparam int unsigned G1_FIXED = G1_W - PAIRS_HI,
  localparam int unsigned N_DIRECT = G2_W + G1_FIXED,
  localparam int unsigned N_OUT    = N_DIRECT + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [G2_W-1:0]   cfg_wr_data,
  output logic [G2_W-1:0]   cfg_rd_data,
  input  logic [G0_W-1:0]   gpio0_irq,
  input  logic [G1_W-1:0]   gpio1_irq,
  input  logic [G2_W-1:0]   gpio2_irq,
  output logic [N_OUT-1:0]  irq_out
);

  logic [G2_W-1:0]     steer;
  logic [N_DIRECT-1:0] direct;
  logic [G0_W-1:0]     spill0;
  logic [PAIRS_HI-1:0] spill1;
  logic [G2_W-1:0]     spill2;
  logic                sh0, sh1, sh2;

  irq_route_cfg_reg #(.WIDTH(G2_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .q       (steer)
  );

  // Lower group: controller 0 against controller 2.
  irq_route_pair #(.PAIRS(G0_W)) u_pair_lo (
    .sel           (steer[G0_W-1:0]),
    .partner_lines (gpio0_irq),
    .wide_lines    (gpio2_irq[G0_W-1:0]),
    .direct        (direct[G0_W-1:0]),
    .partner_spill (spill0),
    .wide_spill    (spill2[G0_W-1:0])
  );

  // Upper group: controller 1 (from its line 0) against controller 2.
  irq_route_pair #(.PAIRS(PAIRS_HI)) u_pair_hi (
    .sel           (steer[G2_W-1:G0_W]),
    .partner_lines (gpio1_irq[PAIRS_HI-1:0]),
    .wide_lines    (gpio2_irq[G2_W-1:G0_W]),
    .direct        (direct[G2_W-1:G0_W]),
    .partner_spill (spill1),
    .wide_spill    (spill2[G2_W-1:G0_W])
  );

  // Unpaired controller 1 lines own the top dedicated outputs.
  if (G1_FIXED > 0) begin : g_fixed
    assign direct[N_DIRECT-1:G2_W] = gpio1_irq[G1_W-1:PAIRS_HI];
  end

  irq_route_merge #(.WIDTH(G0_W))     u_merge0 (.lines(spill0), .any(sh0));
  irq_route_merge #(.WIDTH(PAIRS_HI)) u_merge1 (.lines(spill1), .any(sh1));
  irq_route_merge #(.WIDTH(G2_W))     u_merge2 (.lines(spill2), .any(sh2));

  assign irq_out     = {sh2, sh1, sh0, direct};
  assign cfg_rd_data = steer;

endmodule

// File: rtl/irq_route_checker.sv
module irq_route_checker #(
  parameter int unsigned G0_W = 14,
  parameter int unsigned G1_W = 24,
  parameter int unsigned G2_W = 32,
  localparam int unsigned PAIRS_HI = G2_W - G0_W,
  localparam int unsigned G1_FIXED = G1_W - PAIRS_HI,
  localparam int unsigned N_DIRECT = G2_W + G1_FIXED,
  localparam int unsigned N_OUT    = N_DIRECT + 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic [G2_W-1:0]  cfg_wr_data,
  input logic [G2_W-1:0]  cfg_rd_data,
  input logic [G0_W-1:0]  gpio0_irq,
  input logic [G1_W-1:0]  gpio1_irq,
  input logic [G2_W-1:0]  gpio2_irq,
  input logic [N_OUT-1:0] irq_out
);

  localparam int unsigned SH0 = N_DIRECT;
  localparam int unsigned SH1 = N_DIRECT + 1;
  localparam int unsigned SH2 = N_DIRECT + 2;

  // R2: a write is visible on the next cycle, otherwise the word holds
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_wr_en)) |-> cfg_rd_data == $past(cfg_wr_data));
  assert_word_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cfg_wr_en)) |-> $stable(cfg_rd_data));

  for (genvar i = 0; i < G0_W; i++) begin : g_lo
    assert_lo_spill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_rd_data[i] && gpio2_irq[i]) |-> irq_out[SH2]);
    assert_lo_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_data[i] && gpio0_irq[i]) |-> irq_out[SH0]);
  end

  for (genvar i = G0_W; i < G2_W; i++) begin : g_hi
    assert_hi_spill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_rd_data[i] && gpio2_irq[i]) |-> irq_out[SH2]);
    assert_hi_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_data[i] && gpio1_irq[i-G0_W]) |-> irq_out[SH1]);
  end

  assert_fixed_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out[N_DIRECT-1:G2_W] == gpio1_irq[G1_W-1:PAIRS_HI]);

  assert_quiet_sh0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio0_irq == '0) |-> !irq_out[SH0]);
  assert_quiet_sh1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio1_irq[PAIRS_HI-1:0] == '0) |-> !irq_out[SH1]);
  assert_quiet_sh2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio2_irq == '0) |-> !irq_out[SH2]);

endmodule

bind irq_line_router irq_route_checker #(
  .G0_W (G0_W),
  .G1_W (G1_W),
  .G2_W (G2_W)
) u_route_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_data (cfg_wr_data),
  .cfg_rd_data (cfg_rd_data),
  .gpio0_irq   (gpio0_irq),
  .gpio1_irq   (gpio1_irq),
  .gpio2_irq   (gpio2_irq),
  .irq_out     (irq_out)
);

// File: tb/test_irq_line_router.sv
module test_irq_line_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic [13:0] g0 = '0;
  logic [23:0] g1 = '0;
  logic [31:0] g2 = '0;
  logic [40:0] irq_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  irq_line_router i_irq_line_router (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .gpio0_irq   (g0),
    .gpio1_irq   (g1),
    .gpio2_irq   (g2),
    .irq_out     (irq_out)
  );

  function automatic logic [40:0] model(input logic [31:0] w, input logic [13:0] a,
                                        input logic [23:0] b, input logic [31:0] c);
    logic [40:0] r;
    logic s0, s1, s2, p;
    r = '0; s0 = 0; s1 = 0; s2 = 0;
    for (int i = 0; i < 32; i++) begin
      p = (i < 14) ? a[i] : b[i-14];
      r[i] = w[i] ? c[i] : p;
      if (w[i]) begin
        if (i < 14) s0 |= a[i]; else s1 |= b[i-14];
      end else begin
        s2 |= c[i];
      end
    end
    for (int k = 0; k < 6; k++) r[32+k] = b[18+k];
    r[38] = s0; r[39] = s1; r[40] = s2;
    return r;
  endfunction

  task automatic check(input string req, input logic [40:0] act, input logic [40:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = w;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    #1;
  endtask

  task automatic drive(input logic [13:0] a, input logic [23:0] b, input logic [31:0] c);
    @(negedge clk);
    g0 = a; g1 = b; g2 = c;
    #1;
  endtask

  task automatic t_reset;
    drive('0, '0, '0);
    check("R1 word", {9'd0, cfg_rd_data}, 41'd0);
    check("R1 out", irq_out, 41'd0);
    drive('1, '0, '0);
    check("R1 default routing", irq_out, {27'd0, 14'h3fff});
  endtask

  task automatic t_write_read;
    drive('0, '0, '0);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = 32'hA5A5_5A5A;
    #1;
    check("R2 before edge", {9'd0, cfg_rd_data}, 41'd0);
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wr_data = 32'h1234_5678;
    #1;
    check("R2 after edge", {9'd0, cfg_rd_data}, {9'd0, 32'hA5A5_5A5A});
    @(negedge clk); @(negedge clk); #1;
    check("R2 holds", {9'd0, cfg_rd_data}, {9'd0, 32'hA5A5_5A5A});
    write_word(32'h0F0F_F0F0);
    check("R2 second write", {9'd0, cfg_rd_data}, {9'd0, 32'h0F0F_F0F0});
  endtask

  task automatic t_pairs(input int lo, input int hi, input string tag0, input string tag1);
    logic [13:0] a; logic [23:0] b; logic [31:0] c; logic [40:0] e;
    write_word(32'h0);
    for (int i = lo; i < hi; i++) begin
      a = '0; b = '0; c = '0;
      if (i < 14) a[i] = 1'b1; else b[i-14] = 1'b1;
      drive(a, b, '0);
      e = '0; e[i] = 1'b1;
      check(tag0, irq_out, e);
      c[i] = 1'b1;
      drive('0, '0, c);
      e = '0; e[40] = 1'b1;
      check(tag0, irq_out, e);
    end
    write_word(32'hFFFF_FFFF);
    for (int i = lo; i < hi; i++) begin
      a = '0; b = '0; c = '0;
      c[i] = 1'b1;
      drive('0, '0, c);
      e = '0; e[i] = 1'b1;
      check(tag1, irq_out, e);
      if (i < 14) a[i] = 1'b1; else b[i-14] = 1'b1;
      drive(a, b, '0);
      e = '0; e[(i < 14) ? 38 : 39] = 1'b1;
      check(tag1, irq_out, e);
    end
  endtask

  task automatic t_fixed;
    logic [40:0] e;
    for (int w = 0; w < 2; w++) begin
      write_word(w == 0 ? 32'h0 : 32'hFFFF_FFFF);
      for (int k = 0; k < 6; k++) begin
        logic [23:0] b;
        b = '0; b[18+k] = 1'b1;
        drive('0, b, '0);
        e = '0; e[32+k] = 1'b1;
        check("R7 fixed line", irq_out, e);
      end
    end
  endtask

  task automatic t_seam;
    logic [40:0] e;
    write_word(32'h0000_2000);
    drive(14'h2000, 24'h1, 32'h0000_6000);
    e = '0; e[13] = 1'b1; e[14] = 1'b1; e[38] = 1'b1; e[40] = 1'b1;
    check("R4 R5 seam", irq_out, e);
  endtask

  task automatic t_shared_or;
    logic [40:0] e;
    write_word(32'h0000_0001);
    drive(14'h0001, '0, '0);
    check("R8 single spill", irq_out, model(32'h1, 14'h1, '0, '0));
    drive(14'h0002, '0, '0);
    e = '0; e[1] = 1'b1;
    check("R8 owner not in shared", irq_out, e);
    drive(14'h0003, '0, '0);
    g0 = 14'h0000;
    #1;
    check("R9 same cycle drop", irq_out, 41'd0);
    g2 = 32'h8000_0000;
    #1;
    e = '0; e[40] = 1'b1;
    check("R9 same cycle rise", irq_out, e);
    for (int n = 0; n < 40; n++) begin
      logic [31:0] w; logic [13:0] a; logic [23:0] b; logic [31:0] c;
      w = $urandom; a = 14'($urandom); b = 24'($urandom); c = $urandom;
      if (n % 4 == 0) a = '0;
      if (n % 4 == 1) c = '0;
      write_word(w);
      drive(a, b, c);
      check("R8 random mix", irq_out, model(w, a, b, c));
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_write_read;
    t_pairs(0, 14, "R3 lo owner partner", "R4 lo owner wide");
    t_pairs(14, 32, "R5 hi owner partner", "R6 hi owner wide");
    t_fixed;
    t_seam;
    t_shared_or;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule